// File: doc/BRIEF.md
# Column-to-Row Band Transposer

This block sits between the vertical (column) stage and the horizontal (row) stage of a two-dimensional lifting wavelet transform. The column stage hands over, in each accepted cycle, one low-band and one high-band coefficient for a single column. Successive accepted pairs alternate between an even column and its odd neighbour. The row stage needs something different: two coefficients of the same band that come from that even/odd column pair.

The block keeps three data registers and feeds two output selectors. Once the odd column's pair is accepted, the next cycle presents the low-band samples of both columns, and the cycle after that presents the high-band samples. This keeps the rate at one output pair per input pair, with no line-sized storage.

A line-restart strobe drops any half-collected column pair and any high-band output still owed, so each image line starts on an even column.

Top module: `tpose_reorder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following cycle shows `out_valid` = 0, and the next accepted pair after reset is taken as an even column.
- R2: If an even-column pair (Le,He) and then an odd-column pair (Lo,Ho) are accepted (`in_valid` = 1), the cycle after the odd pair's edge shows `out_valid` = 1, `out_band` = 0 (0 means low band), `out_even` = Le and `out_odd` = Lo.
- R3: The cycle after a low-band output shows `out_valid` = 1, `out_band` = 1 (high band), `out_even` = He and `out_odd` = Ho, whatever `in_valid` is in that cycle, unless `line_start` is asserted in that cycle.
- R4: With `in_valid` held high and no restart, the output is valid every cycle from the third accepted pair onward, and the bands alternate low, high. This gives one output pair per input pair.
- R5: A cycle with `in_valid` = 0 does not advance the even/odd column phase and changes no stored sample. Gaps of any length between or inside column pairs leave the output values unchanged.
- R6: A cycle with `line_start` = 1 discards a stored even pair and any owed high-band output, so the next cycle shows `out_valid` = 0. If `in_valid` is also 1 in that cycle, the pair presented is taken as the even column of the new line.
- R7: `out_valid` is 0 in every cycle that is not a low-band or high-band emission defined by R2 and R3.
- R8: Samples pass through at the full `DATA_W` width without change, including all-ones and sign-bit-only values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_start | input | 1 | Restart strobe: clears column phase and pending output |
| in_valid | input | 1 | Column-stage pair present this cycle |
| in_lo | input | DATA_W | Low-band coefficient of the current column |
| in_hi | input | DATA_W | High-band coefficient of the current column |
| out_valid | output | 1 | Row-ordered pair present |
| out_band | output | 1 | 0 = low band, 1 = high band |
| out_even | output | DATA_W | Sample of the even column |
| out_odd | output | DATA_W | Sample of the odd column |

## Verification
The bench builds the block with `DATA_W` = 12. This width is narrow enough that all-ones (0xFFF) and sign-bit-only (0x800) samples can be driven as explicit edge values, and it confirms that no hidden 16-bit assumption remains in the datapath. The expected stream comes from a queue model: an accepted odd pair pushes one low and one high entry, and a restart clears the queue. This exposes both the emission timing and the restart cases, such as a restart landing on the even column or on the owed high-band cycle.

// File: rtl/tpose_pkg.sv
// Shared types for the column-to-row band transposer.
// Assumes nothing beyond a single clock domain.
package tpose_pkg;

    // Band tag carried with each output pair
    typedef enum logic {
        BAND_LO = 1'b0,
        BAND_HI = 1'b1
    } band_e;

    // Two-bit phase: high-band output owed, odd column expected
    typedef struct packed {
        logic hi_due;
        logic odd_col;
    } phase_t;

endpackage

// File: rtl/tpose_phase_seq.sv
// Phase sequencer: tracks which column of a pair is expected and whether a
// high-band output is owed, and turns that into register loads and selects.
// Assumes line_start may arrive in any cycle, with or without in_valid.
module tpose_phase_seq
    import tpose_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   line_start,
    input  logic   in_valid,
    output logic   load_even,
    output logic   load_odd,
    output logic   emit_lo,
    output logic   emit_hi
);

    phase_t phase_q;
    phase_t phase_d;

    // Decode loads and emissions from the current phase
    always_comb begin
        load_even = in_valid && (line_start || !phase_q.odd_col);
        load_odd  = in_valid && !line_start && phase_q.odd_col;
        emit_lo   = load_odd;
        emit_hi   = phase_q.hi_due && !line_start;
    end

    // Next phase: toggle on accepted pairs, clear on restart
    always_comb begin
        phase_d = phase_q;
        if (line_start) begin
            phase_d.odd_col = 1'b0;
        end
        if (load_even) begin
            phase_d.odd_col = 1'b1;
        end else if (load_odd) begin
            phase_d.odd_col = 1'b0;
        end
        phase_d.hi_due = load_odd;
    end

    // Phase register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end

    // R4: an owed high-band cycle always lands on an even-column slot
    a_r4_hi_on_even_slot: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q.hi_due |-> !phase_q.odd_col);

    // R5: an idle cycle without restart leaves the column phase unchanged
    a_r5_idle_holds_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !line_start) |=> (phase_q.odd_col == $past(phase_q.odd_col)));

endmodule

// File: rtl/tpose_hold_regs.sv
// Three-register store: low and high samples of the even column, and the
// high sample of the odd column. The odd low sample is used straight away.
// Assumes at most one of load_even / load_odd is high in a cycle.
module tpose_hold_regs #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_even,
    input  logic              load_odd,
    input  logic [DATA_W-1:0] in_lo,
    input  logic [DATA_W-1:0] in_hi,
    output logic [DATA_W-1:0] even_lo_q,
    output logic [DATA_W-1:0] even_hi_q,
    output logic [DATA_W-1:0] odd_hi_q
);

    // Capture both bands of the even column
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            even_lo_q <= '0;
            even_hi_q <= '0;
        end else if (load_even) begin
            even_lo_q <= in_lo;
            even_hi_q <= in_hi;
        end
    end

    // Capture the odd column's high band for the following cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odd_hi_q <= '0;
        end else if (load_odd) begin
            odd_hi_q <= in_hi;
        end
    end

    // R5: the even store changes only when an even pair is loaded
    a_r5_even_store_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !load_even |=> $stable(even_lo_q) && $stable(even_hi_q));

endmodule

// File: rtl/tpose_out_stage.sv
// Output stage: two selectors choose the even and odd samples for the
// band being emitted, followed by one output register.
// Assumes emit_lo and emit_hi are never high together.
module tpose_out_stage
    import tpose_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emit_lo,
    input  logic              emit_hi,
    input  logic [DATA_W-1:0] in_lo,
    input  logic [DATA_W-1:0] even_lo_q,
    input  logic [DATA_W-1:0] even_hi_q,
    input  logic [DATA_W-1:0] odd_hi_q,
    output logic              out_valid,
    output logic              out_band,
    output logic [DATA_W-1:0] out_even,
    output logic [DATA_W-1:0] out_odd
);

    logic [DATA_W-1:0] sel_even;
    logic [DATA_W-1:0] sel_odd;

    // Selectors: low band takes the live odd sample, high band the stored one
    always_comb begin
        sel_even = emit_hi ? even_hi_q : even_lo_q;
        sel_odd  = emit_hi ? odd_hi_q  : in_lo;
    end

    // Output register; data holds when nothing is emitted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_band  <= BAND_LO;
            out_even  <= '0;
            out_odd   <= '0;
        end else begin
            out_valid <= emit_lo || emit_hi;
            if (emit_lo || emit_hi) begin
                out_band <= emit_hi ? BAND_HI : BAND_LO;
                out_even <= sel_even;
                out_odd  <= sel_odd;
            end
        end
    end

    // R7: a high-band output is always preceded by a low-band output
    a_r7_hi_after_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_band) |-> ($past(out_valid) && !$past(out_band)));

endmodule

// File: rtl/tpose_reorder.sv
// Column-to-row band transposer top. Converts alternating-column (low, high)
// pairs into same-band (even, odd) pairs for the row stage.
// Assumes the column stage alternates even and odd columns within a line.
module tpose_reorder #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_lo,
    input  logic [DATA_W-1:0] in_hi,
    output logic              out_valid,
    output logic              out_band,
    output logic [DATA_W-1:0] out_even,
    output logic [DATA_W-1:0] out_odd
);

    logic              load_even;
    logic              load_odd;
    logic              emit_lo;
    logic              emit_hi;
    logic [DATA_W-1:0] even_lo_q;
    logic [DATA_W-1:0] even_hi_q;
    logic [DATA_W-1:0] odd_hi_q;

    tpose_phase_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .in_valid   (in_valid),
        .load_even  (load_even),
        .load_odd   (load_odd),
        .emit_lo    (emit_lo),
        .emit_hi    (emit_hi)
    );

    tpose_hold_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_even  (load_even),
        .load_odd   (load_odd),
        .in_lo      (in_lo),
        .in_hi      (in_hi),
        .even_lo_q  (even_lo_q),
        .even_hi_q  (even_hi_q),
        .odd_hi_q   (odd_hi_q)
    );

    tpose_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .emit_lo    (emit_lo),
        .emit_hi    (emit_hi),
        .in_lo      (in_lo),
        .even_lo_q  (even_lo_q),
        .even_hi_q  (even_hi_q),
        .odd_hi_q   (odd_hi_q),
        .out_valid  (out_valid),
        .out_band   (out_band),
        .out_even   (out_even),
        .out_odd    (out_odd)
    );

    // R3: a low-band output is followed by the high band unless restarted
    a_r3_hi_follows_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_band && !line_start) |=> (out_valid && out_band));

    // R2: a low-band output needs an accepted pair on the previous edge
    a_r2_lo_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_band) |-> $past(in_valid));

    // R6: a restart leaves the next cycle without output
    a_r6_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !out_valid);

endmodule

// File: tb/tpose_reorder_bench.sv
// Directed bench for tpose_reorder with a queue reference model.
module tpose_reorder_bench;

    localparam int W = 12;

    typedef struct packed {
        logic         band;
        logic [W-1:0] ev;
        logic [W-1:0] od;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         line_start = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_lo = '0;
    logic [W-1:0] in_hi = '0;
    logic         out_valid;
    logic         out_band;
    logic [W-1:0] out_even;
    logic [W-1:0] out_odd;

    int nchk = 0;
    int nfail = 0;

    exp_t         exp_q[$];
    logic         m_odd = 1'b0;
    logic [W-1:0] m_lo = '0;
    logic [W-1:0] m_hi = '0;

    always #2 clk = ~clk;

    tpose_reorder #(.DATA_W(W)) u_tpose_reorder (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .in_valid   (in_valid),
        .in_lo      (in_lo),
        .in_hi      (in_hi),
        .out_valid  (out_valid),
        .out_band   (out_band),
        .out_even   (out_even),
        .out_odd    (out_odd)
    );

    // One cycle: drive, advance the model, then compare after the edge
    task automatic step(input logic ls, input logic v, input logic [W-1:0] lo,
                        input logic [W-1:0] hi, input string tag);
        exp_t e;
        logic ev_valid;
        @(negedge clk);
        line_start = ls;
        in_valid   = v;
        in_lo      = lo;
        in_hi      = hi;
        if (ls) begin
            exp_q.delete();
            m_odd = 1'b0;
        end
        if (v) begin
            if (!m_odd) begin
                m_lo  = lo;
                m_hi  = hi;
                m_odd = 1'b1;
            end else begin
                exp_q.push_back('{band: 1'b0, ev: m_lo, od: lo});
                exp_q.push_back('{band: 1'b1, ev: m_hi, od: hi});
                m_odd = 1'b0;
            end
        end
        ev_valid = 1'b0;
        e = '0;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            ev_valid = 1'b1;
        end
        @(posedge clk);
        #1;
        nchk++;
        if (out_valid !== ev_valid) begin
            nfail++;
            $display("FAIL %s: out_valid got %b exp %b", tag, out_valid, ev_valid);
        end else if (ev_valid && ({out_band, out_even, out_odd} !== {e.band, e.ev, e.od})) begin
            nfail++;
            $display("FAIL %s: band/even/odd got %b/%h/%h exp %b/%h/%h",
                     tag, out_band, out_even, out_odd, e.band, e.ev, e.od);
        end
    endtask

    // R1: reset clears output and column phase
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b1;
        in_lo = 12'h111;
        in_hi = 12'h222;
        repeat (3) @(posedge clk);
        #1;
        nchk++;
        if (out_valid !== 1'b0) begin
            nfail++;
            $display("FAIL R1: out_valid got %b exp 0", out_valid);
        end
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;
        exp_q.delete();
        m_odd = 1'b0;
        step(1'b0, 1'b1, 12'h0A1, 12'h0B1, "R1");
        step(1'b0, 1'b1, 12'h0A2, 12'h0B2, "R1");
        step(1'b0, 1'b0, '0, '0, "R1");
    endtask

    // R2 R3 R5: one column pair with gaps inside and after
    task automatic t_gaps();
        step(1'b0, 1'b1, 12'h123, 12'h456, "R2");
        step(1'b0, 1'b0, 12'hFFF, 12'hFFF, "R5");
        step(1'b0, 1'b0, 12'hEEE, 12'hDDD, "R5");
        step(1'b0, 1'b1, 12'h789, 12'hABC, "R2");
        step(1'b0, 1'b0, 12'h000, 12'h000, "R3");
        step(1'b0, 1'b0, '0, '0, "R7");
        step(1'b0, 1'b0, '0, '0, "R7");
    endtask

    // R4: continuous random stream
    task automatic t_stream();
        for (int i = 0; i < 60; i++) begin
            step(1'b0, 1'b1, W'($urandom), W'($urandom), "R4");
        end
        step(1'b0, 1'b0, '0, '0, "R4");
        step(1'b0, 1'b0, '0, '0, "R7");
    endtask

    // R3: high band comes out even though the next even column is arriving
    task automatic t_hi_with_input();
        step(1'b0, 1'b1, 12'h301, 12'h302, "R3");
        step(1'b0, 1'b1, 12'h303, 12'h304, "R3");
        step(1'b0, 1'b1, 12'h305, 12'h306, "R3");
        step(1'b0, 1'b0, '0, '0, "R3");
        step(1'b0, 1'b1, 12'h307, 12'h308, "R3");
        step(1'b0, 1'b0, '0, '0, "R3");
        step(1'b0, 1'b0, '0, '0, "R3");
    endtask

    // R6: restart drops a half pair and an owed high band
    task automatic t_restart();
        step(1'b0, 1'b1, 12'h401, 12'h402, "R6");
        step(1'b1, 1'b1, 12'h411, 12'h412, "R6");
        step(1'b0, 1'b1, 12'h421, 12'h422, "R6");
        step(1'b0, 1'b0, '0, '0, "R6");
        step(1'b0, 1'b1, 12'h431, 12'h432, "R6");
        step(1'b0, 1'b1, 12'h441, 12'h442, "R6");
        step(1'b1, 1'b0, '0, '0, "R6");
        step(1'b0, 1'b1, 12'h451, 12'h452, "R6");
        step(1'b0, 1'b1, 12'h461, 12'h462, "R6");
        step(1'b0, 1'b0, '0, '0, "R6");
        step(1'b0, 1'b0, '0, '0, "R7");
    endtask

    // R8: full-width edge values
    task automatic t_width();
        step(1'b0, 1'b1, 12'hFFF, 12'h800, "R8");
        step(1'b0, 1'b1, 12'h800, 12'hFFF, "R8");
        step(1'b0, 1'b1, 12'h000, 12'h7FF, "R8");
        step(1'b0, 1'b1, 12'h001, 12'hFFE, "R8");
        step(1'b0, 1'b0, '0, '0, "R8");
        step(1'b0, 1'b0, '0, '0, "R7");
    endtask

    initial begin
        t_reset();
        t_gaps();
        t_stream();
        t_hi_with_input();
        t_restart();
        t_width();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        #800000;
        nfail++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule